// File: doc/BRIEF.md
# Subtractive Greatest Common Divisor Engine

This block computes the greatest common divisor of two unsigned operands by repeated subtraction, completing one loop step per clock. A low level on the start input, seen while the engine is idle, captures both operands and pulls the ready flag low. The engine then subtracts the smaller register from the larger on every clock until the two registers agree. It copies the common value to the result output and raises ready again.

The engine does not compare the registers first and then subtract. It forms both differences, first-minus-second and second-minus-first, in the same cycle. The borrow out of each subtracter steers the update. A borrow from the first subtraction means the first operand is the smaller, so the second register takes its difference. When neither subtraction borrows, the operands are equal and the loop ends.

The data path has no back-pressure. A request is taken only in the idle state, and the engine ignores the start input at all other times. The requester watches ready to learn when a result is valid. Ready stays high, and the result stays unchanged, until the next accepted request. Zero operands are outside the supported range, because the loop never ends on them. The operand width is a parameter, and a second parameter selects the subtracter build.

Top module: `gcd_sub_engine`

## Requirements
- R1: While the synchronous reset `rst` is high, the engine is idle, `rdy` is 1 and `result` is 0.
- R2: A clock edge with the engine idle and `start_n` at 0 captures `opa` and `opb`, and `rdy` reads 0 after that edge.
- R3: Each clock edge in the compute state performs exactly one step. If first < second, second becomes second − first; otherwise first becomes first − second. For a pair needing k steps, `rdy` first reads 1 after the (k+1)-th edge following the capture edge.
- R4: `result` equals the greatest common divisor of the captured operands. Examples: (27,18)→9, (33,256)→1, (245,45)→5, (121,11)→11, (52,452)→4, (333,121)→1, (125,625)→125, (422,312)→2.
- R5: The "less than" decision comes from the borrow of first − second, and equality from both subtractions being borrow-free. On equality, `result` takes the common value, `rdy` rises, and the engine spends exactly one cycle in a done state before returning to idle.
- R6: While idle with no request, `rdy` stays 1 and `result` stays stable, whatever `opa` and `opb` do.
- R7: `start_n` at 0 during the compute state is ignored. The result and the step count are those of the original operands.
- R8: `start_n` at 0 during the one-cycle done state is ignored. `rdy` stays 1 and `result` keeps its value.
- R9: Equal operands finish with no subtraction step: `rdy` reads 1 after the first edge following capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Request, active low, sampled only while idle |
| opa | input | W | First operand, non-zero |
| opb | input | W | Second operand, non-zero |
| result | output | W | Greatest common divisor, valid while `rdy` is 1 |
| rdy | output | 1 | 1 when idle or done, 0 while computing |

## Verification
The bench builds two instances.

The first uses the default 16-bit width with the behavioural subtracters. It covers the eight listed pairs, equal operands, a large-valued pair, and the handshake corner cases: requests during computation, requests during the done cycle, and idle hold.

The second uses a 6-bit width with the bit-level ripple subtracters. At that width every pair from 1..63 × 1..63 is within reach, so the bench sweeps them all. For each pair it checks both the result and the exact step latency against an arithmetic model.

// File: rtl/gcd_eng_pkg.sv
package gcd_eng_pkg;

  // Control phases of the engine.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_DONE = 2'd2
  } gcd_state_e;

  // Subtracter build selection.
  localparam int SUB_BEHAV  = 0;
  localparam int SUB_RIPPLE = 1;

endpackage

// File: rtl/gcd_ripple_sub.sv
// Bit-level ripple-borrow subtracter: diff = a - b, borrow_o = (a < b).
module gcd_ripple_sub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] diff,
  output logic         borrow_o
);
  logic [W:0] bw;

  assign bw[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prop;
    assign prop      = a[i] ^ b[i];
    assign diff[i]   = prop ^ bw[i];
    assign bw[i+1]   = (~a[i] & b[i]) | (~prop & bw[i]);
  end

  assign borrow_o = bw[W];
endmodule

// File: rtl/gcd_sub_pair.sv
// Forms both differences at once and derives the decision from borrows.
module gcd_sub_pair
  import gcd_eng_pkg::*;
#(
  parameter int W         = 16,
  parameter int SUB_STYLE = SUB_BEHAV
) (
  input  logic [W-1:0] x_q,
  input  logic [W-1:0] y_q,
  output logic [W-1:0] d_xy,
  output logic [W-1:0] d_yx,
  output logic         x_lt_y,
  output logic         x_eq_y
);
  logic bor_xy;
  logic bor_yx;

  if (SUB_STYLE == SUB_RIPPLE) begin : g_ripple
    gcd_ripple_sub #(.W(W)) u_sub_xy (
      .a(x_q), .b(y_q), .diff(d_xy), .borrow_o(bor_xy)
    );
    gcd_ripple_sub #(.W(W)) u_sub_yx (
      .a(y_q), .b(x_q), .diff(d_yx), .borrow_o(bor_yx)
    );
  end else begin : g_behav
    assign {bor_xy, d_xy} = {1'b0, x_q} - {1'b0, y_q};
    assign {bor_yx, d_yx} = {1'b0, y_q} - {1'b0, x_q};
  end

  // A borrow from x-y means x < y.
  assign x_lt_y = bor_xy;
  // Neither direction borrows only when the operands match.
  assign x_eq_y = ~bor_xy & ~bor_yx;
endmodule

// File: rtl/gcd_operand_regs.sv
// Working registers: loaded on request, one of them replaced per step.
module gcd_operand_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step_x,
  input  logic         step_y,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] d_xy,
  input  logic [W-1:0] d_yx,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (load) begin
      x_q <= opa;
      y_q <= opb;
    end else if (step_x) begin
      x_q <= d_xy;
    end else if (step_y) begin
      y_q <= d_yx;
    end
  end
endmodule

// File: rtl/gcd_ctrl.sv
// Three-phase controller plus the result and ready registers.
module gcd_ctrl
  import gcd_eng_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_n,
  input  logic         x_lt_y,
  input  logic         x_eq_y,
  input  logic [W-1:0] x_q,
  output logic         load,
  output logic         step_x,
  output logic         step_y,
  output logic [W-1:0] result,
  output logic         rdy,
  output gcd_state_e   state_q
);
  logic calc;

  assign calc   = (state_q == ST_CALC);
  assign load   = (state_q == ST_IDLE) && !start_n;
  assign step_x = calc && !x_eq_y && !x_lt_y;
  assign step_y = calc && !x_eq_y &&  x_lt_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rdy     <= 1'b1;
      result  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!start_n) begin
            rdy     <= 1'b0;
            state_q <= ST_CALC;
          end
        end
        ST_CALC: begin
          if (x_eq_y) begin
            result  <= x_q;
            rdy     <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gcd_sub_engine.sv
// Top level: subtractive GCD with speculative dual subtraction.
module gcd_sub_engine
  import gcd_eng_pkg::*;
#(
  parameter int W         = 16,
  parameter int SUB_STYLE = SUB_BEHAV
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_n,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic         rdy
);
  logic [W-1:0] x_q;
  logic [W-1:0] y_q;
  logic [W-1:0] d_xy;
  logic [W-1:0] d_yx;
  logic         x_lt_y;
  logic         x_eq_y;
  logic         load;
  logic         step_x;
  logic         step_y;
  gcd_state_e   state_q;

  gcd_sub_pair #(.W(W), .SUB_STYLE(SUB_STYLE)) u_pair (
    .x_q(x_q), .y_q(y_q), .d_xy(d_xy), .d_yx(d_yx),
    .x_lt_y(x_lt_y), .x_eq_y(x_eq_y)
  );

  gcd_operand_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .load(load), .step_x(step_x), .step_y(step_y),
    .opa(opa), .opb(opb), .d_xy(d_xy), .d_yx(d_yx),
    .x_q(x_q), .y_q(y_q)
  );

  gcd_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start_n(start_n),
    .x_lt_y(x_lt_y), .x_eq_y(x_eq_y), .x_q(x_q),
    .load(load), .step_x(step_x), .step_y(step_y),
    .result(result), .rdy(rdy), .state_q(state_q)
  );
endmodule

// File: rtl/gcd_sub_engine_chk.sv
module gcd_sub_engine_chk
  import gcd_eng_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start_n,
  input logic [W-1:0] result,
  input logic         rdy,
  input gcd_state_e   state_q,
  input logic [W-1:0] x_q,
  input logic [W-1:0] y_q
);
  logic [W:0] sum_now;
  assign sum_now = {1'b0, x_q} + {1'b0, y_q};

  AST_LOAD_DROPS_RDY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start_n) |=> (!rdy && state_q == ST_CALC)); // R2

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CALC && x_q != y_q) |=> (sum_now < $past(sum_now))); // R3

  AST_EQ_FINISH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CALC && x_q == y_q) |=>
      (rdy && state_q == ST_DONE && result == $past(x_q))); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE && rdy)); // R8

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (rdy && $past(rdy)) |-> $stable(result)); // R6

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CALC && x_q != y_q) |=> (state_q == ST_CALC && !rdy)); // R7
endmodule

bind gcd_sub_engine gcd_sub_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start_n(start_n), .result(result), .rdy(rdy),
  .state_q(state_q), .x_q(x_q), .y_q(y_q)
);

// File: tb/tb_gcd_sub_engine.sv
module tb_gcd_sub_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 16;
  localparam int WS = 6;
  localparam int WATCHDOG = 195000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst = 1'b1;
  logic          start_b_n = 1'b1;
  logic [WB-1:0] a_b = '0, b_b = '0, res_b;
  logic          rdy_b;
  logic          start_s_n = 1'b1;
  logic [WS-1:0] a_s = '0, b_s = '0, res_s;
  logic          rdy_s;

  gcd_sub_engine #(.W(WB), .SUB_STYLE(0)) dut (
    .clk(clk), .rst(rst), .start_n(start_b_n), .opa(a_b), .opb(b_b),
    .result(res_b), .rdy(rdy_b)
  );

  gcd_sub_engine #(.W(WS), .SUB_STYLE(1)) dut_small (
    .clk(clk), .rst(rst), .start_n(start_s_n), .opa(a_s), .opb(b_s),
    .result(res_s), .rdy(rdy_s)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input int a, input int b, output int g, output int k);
    int x = a;
    int y = b;
    k = 0;
    while (x != y) begin
      if (x < y) y = y - x; else x = x - y;
      k++;
    end
    g = x;
  endfunction

  task automatic run_big(input int a, input int b, input string req);
    int g, k, n;
    model(a, b, g, k);
    @(negedge clk);
    a_b = WB'(a); b_b = WB'(b); start_b_n = 1'b0;
    @(negedge clk);
    start_b_n = 1'b1;
    check(rdy_b == 1'b0, "R2 rdy low after capture", int'(rdy_b), 0);
    n = 0;
    while (!rdy_b && n < 70000) begin @(negedge clk); n++; end
    check(n == k + 1, {req, " R3 latency"}, n, k + 1);
    check(int'(res_b) == g, {req, " result"}, int'(res_b), g);
    @(negedge clk);
  endtask

  task automatic run_small(input int a, input int b);
    int g, k, n;
    model(a, b, g, k);
    @(negedge clk);
    a_s = WS'(a); b_s = WS'(b); start_s_n = 1'b0;
    @(negedge clk);
    start_s_n = 1'b1;
    check(rdy_s == 1'b0, "R2 sweep rdy low", int'(rdy_s), 0);
    n = 0;
    while (!rdy_s && n < 200) begin @(negedge clk); n++; end
    check(n == k + 1, "R3 sweep latency", n, k + 1);
    check(int'(res_s) == g, "R4 sweep result", int'(res_s), g);
    @(negedge clk);
  endtask

  initial begin
    int g, k, n;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(rdy_b == 1'b1, "R1 rdy in reset", int'(rdy_b), 1);
    check(res_b == '0, "R1 result in reset", int'(res_b), 0);
    check(rdy_s == 1'b1, "R1 small rdy in reset", int'(rdy_s), 1);
    rst = 1'b0;
    @(negedge clk);
    check(rdy_b == 1'b1, "R1 rdy after reset", int'(rdy_b), 1);

    // R4: listed pairs
    run_big(27, 18, "R4 27,18");
    run_big(33, 256, "R4 33,256");
    run_big(245, 45, "R4 245,45");
    run_big(121, 11, "R4 121,11");
    run_big(52, 452, "R4 52,452");
    run_big(333, 121, "R4 333,121");
    run_big(125, 625, "R4 125,625");
    run_big(422, 312, "R4 422,312");
    run_big(40000, 30000, "R4 40000,30000");
    // R9: equal operands, zero steps
    run_big(77, 77, "R9 77,77");
    run_big(65535, 65535, "R9 max,max");

    // R7: requests during computation ignored
    model(245, 45, g, k);
    @(negedge clk);
    a_b = 16'd245; b_b = 16'd45; start_b_n = 1'b0;
    @(negedge clk);
    start_b_n = 1'b1;
    n = 0;
    while (!rdy_b && n < 1000) begin
      @(negedge clk); n++;
      if (n == 1) begin a_b = 16'd7; b_b = 16'd3; start_b_n = 1'b0; end
      if (n == 4) start_b_n = 1'b1;
    end
    check(n == k + 1, "R7 latency with busy requests", n, k + 1);
    check(int'(res_b) == g, "R7 result with busy requests", int'(res_b), g);

    // R8: request during done cycle ignored (result 5 held)
    a_b = 16'd6; b_b = 16'd4; start_b_n = 1'b0;
    @(negedge clk);
    start_b_n = 1'b1;
    check(rdy_b == 1'b1, "R8 rdy after done-cycle request", int'(rdy_b), 1);
    check(int'(res_b) == 5, "R8 result after done-cycle request", int'(res_b), 5);
    @(negedge clk);
    check(rdy_b == 1'b1, "R8 no restart", int'(rdy_b), 1);

    // R6: idle hold while operands change
    for (int i = 0; i < 5; i++) begin
      a_b = WB'(100 + i); b_b = WB'(3 * i + 1);
      @(negedge clk);
      check(rdy_b == 1'b1, "R6 rdy held", int'(rdy_b), 1);
      check(int'(res_b) == 5, "R6 result held", int'(res_b), 5);
    end

    // R3 R4 R5: exhaustive sweep on the small, ripple-built instance
    for (int a = 1; a < (1 << WS); a++)
      for (int b = 1; b < (1 << WS); b++)
        run_small(a, b);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule